// File: doc/BRIEF.md
# Dual-Port Overlaid Output Control Register

This block holds a five-bit control word that drives five open-drain enables and can be reached from either of two processor ports. It occupies one word address of a shared memory space. While the overlay-enable input is held low, both ports see the register at that address instead of a memory word. The block then keeps the memory array from being read or written there. While the overlay-enable input is high, the address passes through to the memory like any other location.

Each port supplies a word address, a data word, a chip enable and a write strobe. The block decodes a hit on each port separately. When a port hits the register, the block stores the low five data bits on a write. On every hit it raises that port's memory inhibit and returns the register contents on that port's read-data bus.

Top module: `ovl_drive_reg`

## Requirements
- R1: After reset, all five drive outputs are 0 (off).
- R2: A port's access hits the register only when its chip enable is high, its address equals 1, and the overlay-enable input `ovl_en_ni` is low.
- R3: A write hit (chip enable high, write strobe high) loads data bits 4..0 into the register. The drive outputs show the new value one clock later. Data bits 15..5 have no effect.
- R4: Drive output bit n equals register bit n. A value of 1 means the output sinks to ground (on) and 0 means off.
- R5: Both the left and the right port can write the register.
- R6: When both ports write the register in the same cycle, the left port's data is stored.
- R7: During a hit, that port's read data is combinationally {11'b0, register[4:0]}. Outside a hit it is 0. A read does not change the register.
- R8: A port's memory inhibit output is high exactly when that port's access is a hit.
- R9: While `ovl_en_ni` is high, writes to address 1 do not change the register, and no inhibit is raised.
- R10: Writes to any address other than 1, and writes with chip enable low, do not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ovl_en_ni | input | 1 | Overlay enable, active low |
| l_addr_i | input | 13 | Left port word address |
| l_wdata_i | input | 16 | Left port write data |
| l_ce_i | input | 1 | Left port chip enable |
| l_we_i | input | 1 | Left port write strobe |
| r_addr_i | input | 13 | Right port word address |
| r_wdata_i | input | 16 | Right port write data |
| r_ce_i | input | 1 | Right port chip enable |
| r_we_i | input | 1 | Right port write strobe |
| drive_o | output | 5 | Open-drain enables, 1 = sink |
| l_mem_inh_o | output | 1 | Block left memory access |
| r_mem_inh_o | output | 1 | Block right memory access |
| l_rdata_o | output | 16 | Left port register read data |
| r_rdata_o | output | 16 | Right port register read data |

## Verification
A corrupted register bit reaches `drive_o` in the cycle after the write that caused it. It also appears at once on the read data of any port that hits the register. A wrong hit decode shows up in the same cycle as an inhibit on the wrong port or address, or as a missing inhibit. A write that should have been dropped appears one clock later on `drive_o`. The bench compares every output against a model value after every access.

// File: rtl/ovl_drive_pkg.sv
package ovl_drive_pkg;
  parameter int unsigned ADDR_W  = 13;
  parameter int unsigned DATA_W  = 16;
  parameter int unsigned NUM_OUT = 5;
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              ce;
    logic              we;
  } port_req_t;
endpackage

// File: rtl/ovl_port_dec.sv
module ovl_port_dec
  import ovl_drive_pkg::*;
#(
  parameter int unsigned NOUT = NUM_OUT
) (
  input  port_req_t        req_i,
  input  logic             ovl_en_ni,
  input  logic [NOUT-1:0]  reg_q_i,
  output logic             hit_o,
  output logic             wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PadW = DATA_W - NOUT;

  always_comb begin
    hit_o   = req_i.ce && !ovl_en_ni && (req_i.addr == REG_ADDR);
    wr_o    = hit_o && req_i.we;
    rdata_o = hit_o ? {{PadW{1'b0}}, reg_q_i} : '0;
  end

  always_comb begin
    AST_RDATA_IDLE: assert (hit_o || rdata_o == '0); // R7
  end
endmodule

// File: rtl/ovl_reg_core.sv
module ovl_reg_core
  import ovl_drive_pkg::*;
#(
  parameter int unsigned NOUT = NUM_OUT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            l_wr_i,
  input  logic [NOUT-1:0] l_d_i,
  input  logic            r_wr_i,
  input  logic [NOUT-1:0] r_d_i,
  output logic [NOUT-1:0] q_o
);
  // left port takes priority on a same-cycle collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (l_wr_i) q_o <= l_d_i;
    else if (r_wr_i) q_o <= r_d_i;
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_wr_i && !r_wr_i |=> $stable(q_o)); // R10
  AST_LEFT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_wr_i && r_wr_i |=> q_o == $past(l_d_i)); // R6
  AST_RIGHT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_wr_i && r_wr_i |=> q_o == $past(r_d_i)); // R5
endmodule

// File: rtl/ovl_drive_reg.sv
module ovl_drive_reg
  import ovl_drive_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ovl_en_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_ce_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_ce_i,
  input  logic              r_we_i,
  output logic [NUM_OUT-1:0] drive_o,
  output logic              l_mem_inh_o,
  output logic              r_mem_inh_o,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int unsigned NPorts = 2;

  port_req_t              req   [NPorts];
  logic [NPorts-1:0]      hit, wr;
  logic [DATA_W-1:0]      rdata [NPorts];
  logic [NUM_OUT-1:0]     reg_q;

  assign req[0] = '{addr: l_addr_i, wdata: l_wdata_i, ce: l_ce_i, we: l_we_i};
  assign req[1] = '{addr: r_addr_i, wdata: r_wdata_i, ce: r_ce_i, we: r_we_i};

  for (genvar p = 0; p < NPorts; p++) begin : g_port
    ovl_port_dec #(.NOUT(NUM_OUT)) i_dec (
      .req_i    (req[p]),
      .ovl_en_ni(ovl_en_ni),
      .reg_q_i  (reg_q),
      .hit_o    (hit[p]),
      .wr_o     (wr[p]),
      .rdata_o  (rdata[p])
    );
  end

  ovl_reg_core #(.NOUT(NUM_OUT)) i_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .l_wr_i(wr[0]),
    .l_d_i (l_wdata_i[NUM_OUT-1:0]),
    .r_wr_i(wr[1]),
    .r_d_i (r_wdata_i[NUM_OUT-1:0]),
    .q_o   (reg_q)
  );

  assign drive_o     = reg_q;
  assign l_mem_inh_o = hit[0];
  assign r_mem_inh_o = hit[1];
  assign l_rdata_o   = rdata[0];
  assign r_rdata_o   = rdata[1];

  AST_NO_INH_OVL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl_en_ni |-> !l_mem_inh_o && !r_mem_inh_o); // R9
  AST_OFF_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl_en_ni |=> $stable(drive_o)); // R9
  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_mem_inh_o && l_we_i |=> drive_o == $past(l_wdata_i[NUM_OUT-1:0])); // R3
  AST_READ_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_mem_inh_o |-> r_rdata_o[NUM_OUT-1:0] == drive_o); // R7
endmodule

// File: tb/test_ovl_drive_reg.sv
module test_ovl_drive_reg;
  logic        clk = 0, rst_ni = 0, ovl_en_ni = 1;
  logic [12:0] l_addr = 0, r_addr = 0;
  logic [15:0] l_wdata = 0, r_wdata = 0;
  logic        l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
  logic [4:0]  drive;
  logic        l_inh, r_inh;
  logic [15:0] l_rdata, r_rdata;
  int checks = 0, fails = 0;
  logic [4:0]  model = 0;

  always #2 clk = ~clk;

  ovl_drive_reg i_ovl_drive_reg (
    .clk_i(clk), .rst_ni(rst_ni), .ovl_en_ni(ovl_en_ni),
    .l_addr_i(l_addr), .l_wdata_i(l_wdata), .l_ce_i(l_ce), .l_we_i(l_we),
    .r_addr_i(r_addr), .r_wdata_i(r_wdata), .r_ce_i(r_ce), .r_we_i(r_we),
    .drive_o(drive), .l_mem_inh_o(l_inh), .r_mem_inh_o(r_inh),
    .l_rdata_o(l_rdata), .r_rdata_o(r_rdata));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_ce = 0; l_we = 0; r_ce = 0; r_we = 0;
  endtask

  // drive on negedge, sample before next negedge after posedge
  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr_port(bit left, logic [12:0] a, logic [15:0] d);
    @(negedge clk);
    if (left) begin l_addr = a; l_wdata = d; l_ce = 1; l_we = 1; end
    else begin r_addr = a; r_wdata = d; r_ce = 1; r_we = 1; end
    cyc(); idle();
  endtask

  task automatic t_reset();
    chk("R1", drive, 0);
    chk("R1", {l_inh, r_inh}, 0);
  endtask

  task automatic t_left_write();
    ovl_en_ni = 0;
    wr_port(1, 13'd1, 16'hFFEA);  // upper bits ignored
    model = 5'h0A;
    chk("R3", drive, model);
    chk("R4", drive[1], 1'b1);
  endtask

  task automatic t_right_write();
    wr_port(0, 13'd1, 16'h0015);
    model = 5'h15;
    chk("R5", drive, model);
  endtask

  task automatic t_collide();
    @(negedge clk);
    l_addr = 1; l_wdata = 16'h0003; l_ce = 1; l_we = 1;
    r_addr = 1; r_wdata = 16'h001C; r_ce = 1; r_we = 1;
    cyc(); idle();
    model = 5'h03;
    chk("R6", drive, model);
  endtask

  task automatic t_read();
    @(negedge clk);
    l_addr = 1; l_ce = 1; l_we = 0; r_addr = 1; r_ce = 1; r_we = 0;
    #1;
    chk("R7", l_rdata, {11'b0, model});
    chk("R7", r_rdata, {11'b0, model});
    chk("R8", {l_inh, r_inh}, 2'b11);
    cyc();
    chk("R7", drive, model);
    idle(); #1;
    chk("R7", l_rdata, 0);
    chk("R8", {l_inh, r_inh}, 2'b00);
  endtask

  task automatic t_other_addr();
    wr_port(1, 13'd0, 16'h001F);
    chk("R10", drive, model);
    wr_port(0, 13'd2, 16'h001F);
    chk("R10", drive, model);
    @(negedge clk);
    l_addr = 1; l_wdata = 16'h001F; l_ce = 0; l_we = 1; #1;
    chk("R8", l_inh, 0);
    cyc(); idle();
    chk("R10", drive, model);
    @(negedge clk);
    l_addr = 0; l_ce = 1; #1;
    chk("R2", l_inh, 0);
    idle();
  endtask

  task automatic t_overlay_off();
    @(negedge clk);
    ovl_en_ni = 1;
    l_addr = 1; l_wdata = 16'h001C; l_ce = 1; l_we = 1;
    r_addr = 1; r_wdata = 16'h001C; r_ce = 1; r_we = 1; #1;
    chk("R9", {l_inh, r_inh}, 2'b00);
    chk("R9", l_rdata, 0);
    cyc(); idle();
    chk("R9", drive, model);
    @(negedge clk);
    ovl_en_ni = 0; r_addr = 1; r_ce = 1; #1;
    chk("R2", r_inh, 1);
    idle();
  endtask

  initial begin
    #1;
    chk("R1", drive, 0);
    #10 rst_ni = 1;
    cyc();
    t_reset();
    t_left_write();
    t_right_write();
    t_collide();
    t_read();
    t_other_addr();
    t_overlay_off();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule